// File: doc/BRIEF.md
# Quadratic-Residue Radix-2 Frequency-Decimation Butterfly

This block is one butterfly of a small transform engine that runs complex arithmetic in quadratic residue form. A complex integer `x + iy` is carried as two residues modulo a modulus `m` with `m mod 4 = 1`. Such a modulus has a value `j` with `j*j = -1 (mod m)`. The pair is `z = (x + j*y) mod m` and `zc = (x - j*y) mod m`. In this form a complex product is simply two separate modular products, one per component, with no cross terms.

The block accepts two operands as signed two's-complement integers (real and imaginary parts) and converts them into residue pairs. It then forms their component-wise modular sum, and their component-wise modular difference multiplied by a twiddle factor. The twiddle factor is supplied already in residue-pair form. For purely real data, a mode input forces the imaginary parts to zero, so each operand's conversion reduces to a single reduction of its real part. The modulus and its root are picked at elaboration from a fixed set of four. One result leaves the block per accepted input, three clock cycles later, and inputs may arrive back to back.

Top module: `qrns_dif_butterfly`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted input has travelled through, `out_valid` is low.
- R2: Each cycle with `in_valid` high produces exactly one result. `out_valid` rises three clock edges after the edge that accepted the input, and results leave in input order.
- R3: The operands are mapped with `z = (re + j*im) mod m` and `zc = (re - j*im) mod m`, taking `re` and `im` as signed two's-complement values.
- R4: `sum_z = (Az + Bz) mod m` and `sum_zc = (Azc + Bzc) mod m`, where A and B are the mapped operands.
- R5: `dif_z = ((Az - Bz) mod m) * tw_z mod m` and `dif_zc = ((Azc - Bzc) mod m) * tw_zc mod m`, each component computed on its own. The twiddle residues must be below `m`.
- R6: When `in_real` is high, `a_im` and `b_im` have no effect. Each operand maps to `z = zc = re mod m`.
- R7: Every output residue lies in `0 .. m-1` while `out_valid` is high.
- R8: `MOD_SEL` values 0, 1, 2 and 3 select the moduli 221, 229, 233 and 241, paired with the roots 47, 107, 89 and 177.
- R9: The sum outputs equal the mapped pair of the complex sum `a + b`. The difference outputs equal the mapped pair of the complex product `(a - b) * w`, where `w` is the complex twiddle whose mapped pair is on `tw_z/tw_zc`.
- R10: While `out_valid` is low, the four output residues keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| in_valid | input | 1 | Operands and twiddle are presented this cycle |
| in_real | input | 1 | Treat both operands as real; imaginary inputs ignored |
| a_re | input | IN_W | Operand A real part, signed |
| a_im | input | IN_W | Operand A imaginary part, signed |
| b_re | input | IN_W | Operand B real part, signed |
| b_im | input | IN_W | Operand B imaginary part, signed |
| tw_z | input | RW | Twiddle residue, `+j` component |
| tw_zc | input | RW | Twiddle residue, `-j` component |
| out_valid | output | 1 | Result present on the outputs |
| sum_z | output | RW | Sum, `+j` component |
| sum_zc | output | RW | Sum, `-j` component |
| dif_z | output | RW | Twiddled difference, `+j` component |
| dif_zc | output | RW | Twiddled difference, `-j` component |

## Verification
The bench builds two instances side by side, with `MOD_SEL = 0` (modulus 221, which is composite) and `MOD_SEL = 3` (modulus 241, the largest). Both instances see the same stimulus.

With the largest modulus, 8-bit extremes come within a few counts of `m`, so the wrap-around paths of the modular add, subtract and signed reduction are exercised. With the composite modulus, the root-of-minus-one relation is exercised on a modulus that is not prime.

Expected values come from complex integer arithmetic that is reduced and mapped only at the end. This checks the per-component shortcut against the ordinary complex product, under back-to-back, gapped, real-mode and extreme-value traffic.

// File: rtl/qrns_pkg.sv
package qrns_pkg;

  // Largest supported modulus sets the residue width.
  localparam int MAX_MOD = 241;
  localparam int RW      = $clog2(MAX_MOD + 1);

  // Residue pair: index 1 holds the +j component, index 0 the -j component.
  localparam int QZ  = 1;
  localparam int QZC = 0;
  typedef logic [1:0][RW-1:0] qpair_t;

  // Modulus table, selected by index (R8).
  function automatic int qr_modulus(input int sel);
    case (sel)
      0:       return 221;
      1:       return 229;
      2:       return 233;
      default: return 241;
    endcase
  endfunction

  // Square root of minus one for each modulus (R8).
  function automatic int qr_root(input int sel);
    case (sel)
      0:       return 47;
      1:       return 107;
      2:       return 89;
      default: return 177;
    endcase
  endfunction

  // Signed integer to residue in 0..m-1.
  function automatic logic [RW-1:0] qr_smod(input int v, input int m);
    int r;
    r = v % m;
    if (r < 0) r = r + m;
    return RW'(r);
  endfunction

  // Modular add of two reduced residues: one compare, one conditional subtract.
  function automatic logic [RW-1:0] qr_add(input logic [RW-1:0] a,
                                           input logic [RW-1:0] b,
                                           input int m);
    int s;
    s = int'(a) + int'(b);
    if (s >= m) s = s - m;
    return RW'(s);
  endfunction

  // Modular subtract of two reduced residues.
  function automatic logic [RW-1:0] qr_sub(input logic [RW-1:0] a,
                                           input logic [RW-1:0] b,
                                           input int m);
    int s;
    s = int'(a) - int'(b);
    if (s < 0) s = s + m;
    return RW'(s);
  endfunction

  // Modular multiply of two reduced residues.
  function automatic logic [RW-1:0] qr_mul(input logic [RW-1:0] a,
                                           input logic [RW-1:0] b,
                                           input int m);
    int p;
    p = (int'(a) * int'(b)) % m;
    return RW'(p);
  endfunction

endpackage

// File: rtl/qrns_fwd_map.sv
module qrns_fwd_map
  import qrns_pkg::*;
#(
  parameter int IN_W = 8,
  parameter int M    = 221,
  parameter int J    = 47
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   real_mode,
  input  logic signed [IN_W-1:0] x,
  input  logic signed [IN_W-1:0] y,
  output qpair_t                 q
);

  logic [RW-1:0] x_res;
  logic [RW-1:0] y_res;
  logic [RW-1:0] jy_res;
  qpair_t        q_d;

  // Next state: reduce both parts, scale the imaginary residue by the root,
  // then one modular add and one modular subtract.
  always_comb begin
    x_res    = qr_smod(int'(x), M);
    y_res    = real_mode ? '0 : qr_smod(int'(y), M);
    jy_res   = qr_mul(RW'(J), y_res, M);
    q_d[QZ]  = qr_add(x_res, jy_res, M);
    q_d[QZC] = qr_sub(x_res, jy_res, M);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= q_d;
    end
  end

  // A real operand maps to two equal components.
  assert_real_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && real_mode) |=> (q[QZ] == q[QZC]))
    else $error("real operand mapped to unequal components");

endmodule

// File: rtl/qrns_addsub.sv
module qrns_addsub
  import qrns_pkg::*;
#(
  parameter int M = 221
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  qpair_t a,
  input  qpair_t b,
  output qpair_t sum_q,
  output qpair_t dif_q
);

  qpair_t sum_d;
  qpair_t dif_d;

  for (genvar c = 0; c < 2; c++) begin : g_comp
    assign sum_d[c] = qr_add(a[c], b[c], M);
    assign dif_d[c] = qr_sub(a[c], b[c], M);

    // Sum plus difference must equal twice operand A, per component.
    assert_sum_dif_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (qr_add(sum_q[c], dif_q[c], M) == qr_add($past(a[c]), $past(a[c]), M)))
      else $error("sum and difference are inconsistent in component %0d", c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      dif_q <= '0;
    end else if (en) begin
      sum_q <= sum_d;
      dif_q <= dif_d;
    end
  end

endmodule

// File: rtl/qrns_pair_mul.sv
module qrns_pair_mul
  import qrns_pkg::*;
#(
  parameter int M = 221
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  qpair_t d,
  input  qpair_t w,
  output qpair_t p_q
);

  qpair_t p_d;

  // One independent modular product per component, no cross terms.
  for (genvar c = 0; c < 2; c++) begin : g_comp
    assign p_d[c] = qr_mul(d[c], w[c], M);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
    end else if (en) begin
      p_q <= p_d;
    end
  end

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(p_q))
    else $error("product changed without an enable");

endmodule

// File: rtl/qrns_dif_butterfly.sv
module qrns_dif_butterfly
  import qrns_pkg::*;
#(
  parameter int MOD_SEL = 0,
  parameter int IN_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_real,
  input  logic signed [IN_W-1:0] a_re,
  input  logic signed [IN_W-1:0] a_im,
  input  logic signed [IN_W-1:0] b_re,
  input  logic signed [IN_W-1:0] b_im,
  input  logic [RW-1:0]          tw_z,
  input  logic [RW-1:0]          tw_zc,
  output logic                   out_valid,
  output logic [RW-1:0]          sum_z,
  output logic [RW-1:0]          sum_zc,
  output logic [RW-1:0]          dif_z,
  output logic [RW-1:0]          dif_zc
);

  localparam int M     = qr_modulus(MOD_SEL);
  localparam int J     = qr_root(MOD_SEL);
  localparam int N_OPS = 2;

  // Reset: asserted at once, released on the clock through two flops.
  logic rst_s1;
  logic rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  // Valid pipeline: map, add/sub, multiply.
  logic v1, v2, v3;
  logic v1_d, v2_d, v3_d;

  always_comb begin
    v1_d = in_valid;
    v2_d = v1;
    v3_d = v2;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= v1_d;
      v2 <= v2_d;
      v3 <= v3_d;
    end
  end

  // Stage 1: forward mapping of both operands.
  logic signed [IN_W-1:0] op_re [N_OPS];
  logic signed [IN_W-1:0] op_im [N_OPS];
  qpair_t                 op_q  [N_OPS];

  assign op_re[0] = a_re;
  assign op_im[0] = a_im;
  assign op_re[1] = b_re;
  assign op_im[1] = b_im;

  for (genvar k = 0; k < N_OPS; k++) begin : g_map
    qrns_fwd_map #(
      .IN_W (IN_W),
      .M    (M),
      .J    (J)
    ) i_map (
      .clk       (clk),
      .rst_n     (rst_i),
      .en        (in_valid),
      .real_mode (in_real),
      .x         (op_re[k]),
      .y         (op_im[k]),
      .q         (op_q[k])
    );
  end

  // Twiddle travels alongside the data until the multiply stage.
  qpair_t tw_in;
  qpair_t tw_s1, tw_s2;

  always_comb begin
    tw_in[QZ]  = tw_z;
    tw_in[QZC] = tw_zc;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      tw_s1 <= '0;
      tw_s2 <= '0;
    end else begin
      if (in_valid) tw_s1 <= tw_in;
      if (v1)       tw_s2 <= tw_s1;
    end
  end

  // Stage 2: component-wise sum and difference.
  qpair_t sum_s2, dif_s2;

  qrns_addsub #(
    .M (M)
  ) i_addsub (
    .clk   (clk),
    .rst_n (rst_i),
    .en    (v1),
    .a     (op_q[0]),
    .b     (op_q[1]),
    .sum_q (sum_s2),
    .dif_q (dif_s2)
  );

  // Stage 3: difference times twiddle; sum is delayed to stay aligned.
  qpair_t sum_s3, prod_s3;

  qrns_pair_mul #(
    .M (M)
  ) i_mul (
    .clk   (clk),
    .rst_n (rst_i),
    .en    (v2),
    .d     (dif_s2),
    .w     (tw_s2),
    .p_q   (prod_s3)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sum_s3 <= '0;
    end else if (v2) begin
      sum_s3 <= sum_s2;
    end
  end

  assign out_valid = v3;
  assign sum_z     = sum_s3[QZ];
  assign sum_zc    = sum_s3[QZC];
  assign dif_z     = prod_s3[QZ];
  assign dif_zc    = prod_s3[QZC];

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_i)
    in_valid |=> ##2 out_valid)
    else $error("accepted input did not reach the output after three edges");

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_i)
    !in_valid |=> ##2 !out_valid)
    else $error("output valid without a matching input");

  assert_in_range_R7: assert property (@(posedge clk) disable iff (!rst_i)
    out_valid |-> (int'(sum_z) < M && int'(sum_zc) < M &&
                   int'(dif_z) < M && int'(dif_zc) < M))
    else $error("output residue not reduced");

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_i |-> !out_valid)
    else $error("output valid while in reset");

endmodule

// File: tb/test_qrns_dif_butterfly.sv
module test_qrns_dif_butterfly;

  localparam int IN_W = 8;
  localparam int RW   = qrns_pkg::RW;
  localparam int M0 = 221, J0 = 47;   // MOD_SEL = 0 (R8)
  localparam int M1 = 241, J1 = 177;  // MOD_SEL = 3 (R8)

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_real;
  logic signed [IN_W-1:0] a_re, a_im, b_re, b_im;
  logic [RW-1:0] tw0_z, tw0_zc, tw1_z, tw1_zc;
  logic          ov0, ov1;
  logic [RW-1:0] s0z, s0zc, d0z, d0zc, s1z, s1zc, d1z, d1zc;

  always #5 clk = ~clk;

  qrns_dif_butterfly #(.MOD_SEL(0), .IN_W(IN_W)) i_qrns_dif_butterfly (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_real(in_real),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .tw_z(tw0_z), .tw_zc(tw0_zc), .out_valid(ov0),
    .sum_z(s0z), .sum_zc(s0zc), .dif_z(d0z), .dif_zc(d0zc));

  qrns_dif_butterfly #(.MOD_SEL(3), .IN_W(IN_W)) i_qrns_dif_butterfly_m241 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_real(in_real),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .tw_z(tw1_z), .tw_zc(tw1_zc), .out_valid(ov1),
    .sum_z(s1z), .sum_zc(s1zc), .dif_z(d1z), .dif_zc(d1zc));

  typedef struct {
    int sz, szc, dz, dzc, cyc;
  } exp_t;

  exp_t q0[$];
  exp_t q1[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   cyc   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pm(input int v, input int m);
    int r;
    r = v % m;
    if (r < 0) r = r + m;
    return r;
  endfunction

  // Complex value to residue pair (R3).
  function automatic void cmap(input int x, input int y, input int m, input int j,
                               output int z, output int zc);
    z  = pm(x + pm(j * pm(y, m), m), m);
    zc = pm(x - pm(j * pm(y, m), m), m);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Expected item from complex integer arithmetic (R9).
  function automatic exp_t expect_item(input int ar, input int ai, input int br, input int bi,
                                       input int wr, input int wi, input int m, input int j,
                                       input int at);
    exp_t e;
    int dr, di, pr, pi;
    dr = ar - br;
    di = ai - bi;
    pr = dr * wr - di * wi;
    pi = dr * wi + di * wr;
    cmap(ar + br, ai + bi, m, j, e.sz, e.szc);
    cmap(pr, pi, m, j, e.dz, e.dzc);
    e.cyc = at;
    return e;
  endfunction

  task automatic drive(input int ar, input int ai, input int br, input int bi,
                       input int wr, input int wi, input bit rl);
    int t0z, t0zc, t1z, t1zc, eai, ebi;
    @(negedge clk);
    eai = rl ? 0 : ai;   // R6: imaginary parts ignored in real mode
    ebi = rl ? 0 : bi;
    cmap(wr, wi, M0, J0, t0z, t0zc);
    cmap(wr, wi, M1, J1, t1z, t1zc);
    a_re = IN_W'(ar); a_im = IN_W'(ai);
    b_re = IN_W'(br); b_im = IN_W'(bi);
    tw0_z = RW'(t0z); tw0_zc = RW'(t0zc);
    tw1_z = RW'(t1z); tw1_zc = RW'(t1zc);
    in_real  = rl;
    in_valid = 1'b1;
    q0.push_back(expect_item(ar, eai, br, ebi, wr, wi, M0, J0, cyc + 3));
    q1.push_back(expect_item(ar, eai, br, ebi, wr, wi, M1, J1, cyc + 3));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a_re = IN_W'($urandom_range(255));  // junk while idle must not matter
      b_im = IN_W'($urandom_range(255));
    end
  endtask

  function automatic int rnd8();
    return int'($urandom_range(255)) - 128;
  endfunction

  // Monitors: pop and compare (R2, R4, R5, R7, R9, R10).
  bit   live = 1'b0;
  bit   seen0 = 1'b0, seen1 = 1'b0;
  exp_t last0, last1;

  always @(negedge clk) begin
    if (live) begin
      if (ov0) begin
        if (q0.size() == 0) begin
          chk(1'b0, "R2", "m221 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q0.pop_front();
          chk(cyc == e.cyc, "R2", "m221 latency cycle", cyc, e.cyc);
          chk(int'(s0z) == e.sz && int'(s0zc) == e.szc, "R4/R9", "m221 sum_z*256+sum_zc",
              int'(s0z) * 256 + int'(s0zc), e.sz * 256 + e.szc);
          chk(int'(d0z) == e.dz && int'(d0zc) == e.dzc, "R5/R9", "m221 dif_z*256+dif_zc",
              int'(d0z) * 256 + int'(d0zc), e.dz * 256 + e.dzc);
          last0 = e;
          seen0 = 1'b1;
        end
      end else if (seen0) begin
        chk(int'(s0z) == last0.sz && int'(d0zc) == last0.dzc, "R10", "m221 held sum_z",
            int'(s0z), last0.sz);
      end
      if (ov1) begin
        if (q1.size() == 0) begin
          chk(1'b0, "R2", "m241 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q1.pop_front();
          chk(cyc == e.cyc, "R2", "m241 latency cycle", cyc, e.cyc);
          chk(int'(s1z) == e.sz && int'(s1zc) == e.szc, "R4/R9", "m241 sum_z*256+sum_zc",
              int'(s1z) * 256 + int'(s1zc), e.sz * 256 + e.szc);
          chk(int'(d1z) == e.dz && int'(d1zc) == e.dzc, "R5/R9", "m241 dif_z*256+dif_zc",
              int'(d1z) * 256 + int'(d1zc), e.dz * 256 + e.dzc);
          chk(int'(s1z) < M1 && int'(d1z) < M1, "R7", "m241 residue range", int'(d1z), M1 - 1);
          last1 = e;
          seen1 = 1'b1;
        end
      end else if (seen1) begin
        chk(int'(d1z) == last1.dz && int'(s1zc) == last1.szc, "R10", "m241 held dif_z",
            int'(d1z), last1.dz);
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual %0d expected %0d cycles", cyc, 100000);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_real = 1'b0;
    a_re = '0; a_im = '0; b_re = '0; b_im = '0;
    tw0_z = '0; tw0_zc = '0; tw1_z = '0; tw1_zc = '0;
    repeat (3) @(negedge clk);
    chk(!ov0 && !ov1, "R1", "out_valid during reset", int'(ov0 | ov1), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!ov0 && !ov1, "R1", "out_valid after reset release", int'(ov0 | ov1), 0);
    live = 1'b1;

    drive(0, 0, 0, 0, 1, 0, 1'b0);             // all zero
    drive(127, 127, -128, -128, 1, 0, 1'b0);   // extremes, unit twiddle
    drive(-128, 127, 127, -128, 127, -128, 1'b0);
    drive(5, 3, 2, 1, 0, 1, 1'b0);             // twiddle = i (R3 root path)
    drive(5, 3, 2, 1, 0, -1, 1'b0);
    drive(40, 99, -7, -60, 13, 22, 1'b1);      // R6: imag ignored
    drive(40, -1, -7, 17, 13, 22, 1'b1);       // R6: same real parts, other imag
    drive(-128, 55, -128, -55, -128, 0, 1'b1); // R6 with negative extremes
    idle(6);

    for (int n = 0; n < 60; n++) begin         // back-to-back random
      drive(rnd8(), rnd8(), rnd8(), rnd8(), rnd8(), rnd8(), ($urandom_range(3) == 0));
    end
    for (int n = 0; n < 40; n++) begin         // gapped random
      drive(rnd8(), rnd8(), rnd8(), rnd8(), rnd8(), rnd8(), ($urandom_range(3) == 0));
      idle(int'($urandom_range(3)));
    end
    idle(10);
    chk(q0.size() == 0 && q1.size() == 0, "R2", "results outstanding",
        q0.size() + q1.size(), 0);
    finish_run();
  end

endmodule